// File: doc/BRIEF.md
# Mode-gated SCSI command sequencer

This block is the command-register front end of a small SCSI protocol controller. The host writes command bytes and a few configuration and counter registers through a simple register-write port. Every command byte is screened against the connection mode the controller holds, which is either disconnected or initiator. A rejected byte is kept in the command register but is not executed. It sets an illegal-command status flag and raises the interrupt line.

Accepted commands drive a small sequencer. Selection asks a target-present input whether a device answered. A successful selection moves the controller into initiator mode but holds back the interrupt until the device requests data. A missing target drops the controller back to disconnected and reports a disconnect. A message-accepted command also returns the controller to disconnected.

A 16-bit DMA transfer counter is decremented by each burst the block issues towards memory. A burst whose computed length is zero issues no memory request and leaves the counter alone.

Top module: `scsi_cmd_front`

## Requirements
- R1: After reset the mode is disconnected (`mode_ini`=0), the configuration register (address 5) reads 7, and the command (0), status (1), interrupt (2), step (3), flags (4) and counter (6 low byte, 7 high byte) registers read 0. `irq` is low.
- R2: The command group is bits [6:4] of the byte, and bit 7 (DMA flag) plays no part in legality. Group 0 (miscellaneous) is accepted in both modes.
- R3: In disconnected mode group 4 is accepted and group 1 is rejected. In initiator mode group 1 is accepted and group 4 is rejected. Groups 2, 3, 5, 6 and 7 are rejected in both modes.
- R4: A rejected byte is latched into the command register, sets status bit 7 and raises `irq`. It leaves the mode, the interrupt register and the step register unchanged. Accepted bytes other than the four commands below only latch.
- R5: Select (0x41 without attention, 0x42 with attention; bit 7 free) with `target_present`=1 sets `mode_ini` on the next cycle and does not raise `irq`.
- R6: On the next `dev_req` after a successful select, 0x41 ORs interrupt bits 4 (bus service) and 3 (function complete) in and sets step 4. 0x42 ORs bit 4 in and sets step 1. Both raise `irq`.
- R7: Select, or transfer-information (0x10), with `target_present`=0 sets disconnected mode and clears status. It loads the interrupt register with exactly bit 5 (disconnect), sets step 0 and raises `irq`.
- R8: Transfer-information with a target present waits for `dev_req`. It then clears the command register, ORs interrupt bit 4 in and raises `irq`.
- R9: Message-accepted (0x12) sets disconnected mode, ORs interrupt bit 5 in, clears the step and flags registers and raises `irq`.
- R10: A read strobe at address 2 returns the interrupt register. On the next cycle it clears that register and status bit 7 and drops `irq`.
- R11: A burst strobe moves len = min(counter, `dma_room`). If len is 0, no `mem_req` pulse occurs and the counter is unchanged. Otherwise a one-cycle `mem_req` pulse occurs with `mem_len` = len and the counter falls by len, never below 0.
- R12: Whenever a pending select or transfer is completed by `dev_req`, the flags register loads `dev_phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clear-on-read side effect) |
| addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr` |
| target_present | input | 1 | A target answers selection / command phase |
| dev_req | input | 1 | Device asks for data (phase begins) |
| dev_phase | input | 3 | Phase code reported with `dev_req` |
| burst_go | input | 1 | Start a DMA burst |
| dma_room | input | TC_W | Bytes the memory side can move now |
| mem_req | output | 1 | One-cycle memory access request |
| mem_len | output | TC_W | Length of the requested access |
| mode_ini | output | 1 | 1 = initiator mode, 0 = disconnected |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default DATA_W=8 and TC_W=16. This means the counter is written through two byte registers, and random counter values reach across both bytes. Random command bytes cover all eight groups with the DMA bit set and clear in both modes. The burst test mixes zero counters, zero room and full-range values, so the min(), zero-length and exact-exhaustion cases all occur.

// File: rtl/scf_pkg.sv
// Shared constants for the mode-gated command sequencer.
// Assumes an 8-bit register data path.
package scf_pkg;
    localparam int ADDR_W = 3;
    localparam logic [2:0] A_CMD = 3'd0, A_STAT = 3'd1, A_INTR = 3'd2, A_STEP = 3'd3,
                           A_FLAGS = 3'd4, A_CFG = 3'd5, A_TCL = 3'd6, A_TCH = 3'd7;
    localparam logic [2:0] G_MISC = 3'd0, G_INIT = 3'd1, G_DISC = 3'd4;
    localparam logic [6:0] C_SEL_N = 7'h41, C_SEL_A = 7'h42, C_XFER = 7'h10, C_MSGOK = 7'h12;
    localparam int I_DC = 5, I_BS = 4, I_FC = 3, S_ILL = 7;
    typedef enum logic [1:0] {P_NONE, P_SEL_N, P_SEL_A, P_XFER} pend_e;
endpackage

// File: rtl/scf_cmd_screen.sv
// Legality screen: decides whether a command group may run in the current mode.
// Assumes group codes misc=0, initiator=1, disconnected=4; all others illegal.
module scf_cmd_screen
    import scf_pkg::*;
(
    input  logic       mode_ini,
    input  logic [2:0] group,
    output logic       legal
);
    // Misc group always legal; otherwise the group must match the mode.
    always_comb begin
        legal = (group == G_MISC) || (mode_ini ? (group == G_INIT) : (group == G_DISC));
    end
endmodule

// File: rtl/scf_tc_unit.sv
// DMA transfer counter: host-loaded by byte, decremented by each non-zero burst.
// Assumes TC_W = 2*DATA_W; a host write in the same cycle wins over a burst.
module scf_tc_unit #(
    parameter int DATA_W = 8,
    parameter int TC_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              burst_go,
    input  logic [TC_W-1:0]   room,
    output logic [TC_W-1:0]   tc_q,
    output logic              mem_req,
    output logic [TC_W-1:0]   mem_len
);
    logic [TC_W-1:0] len;
    logic            host_wr;

    // Burst length is the smaller of counter and room.
    always_comb begin
        len     = (tc_q < room) ? tc_q : room;
        host_wr = wr_lo | wr_hi;
    end

    // Counter update and memory request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q    <= '0;
            mem_req <= 1'b0;
            mem_len <= '0;
        end else begin
            mem_req <= 1'b0;
            if (wr_lo) tc_q[DATA_W-1:0]    <= wdata;
            if (wr_hi) tc_q[TC_W-1:DATA_W] <= wdata;
            if (burst_go && !host_wr && len != '0) begin
                tc_q    <= tc_q - len;
                mem_req <= 1'b1;
                mem_len <= len;
            end
        end
    end

    // R11
    zero_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_go && !host_wr && (tc_q == '0 || room == '0)) |=> (!mem_req && tc_q == $past(tc_q)));
    // R11
    mem_len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0));
    // R11
    tc_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> (tc_q <= $past(tc_q)));
endmodule

// File: rtl/scf_seq_ctrl.sv
// Command sequencer: mode tracking, command execution, interrupt/step/status/flags registers.
// Assumes legality is computed outside from the current mode; phase events come on dev_req.
module scf_seq_ctrl
    import scf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cfg_wr,
    input  logic              intr_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              legal,
    input  logic              target_present,
    input  logic              dev_req,
    input  logic [2:0]        dev_phase,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] intr_q,
    output logic [DATA_W-1:0] step_q,
    output logic [DATA_W-1:0] flags_q,
    output logic [DATA_W-1:0] cfg_q,
    output logic              mode_ini,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CFG_RST = DATA_W'(7);
    pend_e      pend_q;
    logic [6:0] op;

    // Opcode without the DMA flag.
    always_comb op = wdata[6:0];

    // Register, mode and pending-phase update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0; stat_q <= '0; intr_q <= '0; step_q <= '0; flags_q <= '0;
            cfg_q <= CFG_RST; mode_ini <= 1'b0; irq <= 1'b0; pend_q <= P_NONE;
        end else begin
            if (intr_rd) begin
                intr_q <= '0;
                stat_q[S_ILL] <= 1'b0;
                irq <= 1'b0;
            end
            if (cfg_wr) cfg_q <= wdata;
            if (dev_req && pend_q != P_NONE) begin
                flags_q <= DATA_W'(dev_phase);
                irq     <= 1'b1;
                pend_q  <= P_NONE;
                case (pend_q)
                    P_SEL_N: begin
                        intr_q <= intr_q | DATA_W'((1 << I_BS) | (1 << I_FC));
                        step_q <= DATA_W'(4);
                    end
                    P_SEL_A: begin
                        intr_q <= intr_q | DATA_W'(1 << I_BS);
                        step_q <= DATA_W'(1);
                    end
                    default: begin
                        cmd_q  <= '0;
                        intr_q <= intr_q | DATA_W'(1 << I_BS);
                    end
                endcase
            end
            if (cmd_wr) begin
                cmd_q <= wdata;
                if (!legal) begin
                    stat_q[S_ILL] <= 1'b1;
                    irq <= 1'b1;
                end else if ((op == C_SEL_N || op == C_SEL_A || op == C_XFER) && !target_present) begin
                    mode_ini <= 1'b0;
                    stat_q   <= '0;
                    intr_q   <= DATA_W'(1 << I_DC);
                    step_q   <= '0;
                    irq      <= 1'b1;
                    pend_q   <= P_NONE;
                end else if (op == C_SEL_N || op == C_SEL_A) begin
                    mode_ini <= 1'b1;
                    pend_q   <= (op == C_SEL_N) ? P_SEL_N : P_SEL_A;
                end else if (op == C_XFER) begin
                    pend_q <= P_XFER;
                end else if (op == C_MSGOK) begin
                    mode_ini <= 1'b0;
                    intr_q   <= intr_q | DATA_W'(1 << I_DC);
                    step_q   <= '0;
                    flags_q  <= '0;
                    irq      <= 1'b1;
                    pend_q   <= P_NONE;
                end
            end
        end
    end

    // R4
    illegal_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !legal) |=> (mode_ini == $past(mode_ini) && step_q == $past(step_q)));
    // R5
    sel_holds_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && legal && (op == C_SEL_N || op == C_SEL_A) && target_present && !irq && !dev_req)
        |=> (mode_ini && !irq));
    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_rd && !cmd_wr && !dev_req) |=> (!irq && intr_q == '0));
    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_wr || dev_req));
endmodule

// File: rtl/scsi_cmd_front.sv
// Top: register decode, legality screen, sequencer and transfer counter.
// Assumes read data is combinational from addr; rd_en only triggers clear-on-read.
module scsi_cmd_front
    import scf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TC_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              target_present,
    input  logic              dev_req,
    input  logic [2:0]        dev_phase,
    input  logic              burst_go,
    input  logic [TC_W-1:0]   dma_room,
    output logic              mem_req,
    output logic [TC_W-1:0]   mem_len,
    output logic              mode_ini,
    output logic              irq
);
    logic legal;
    logic [DATA_W-1:0] cmd_q, stat_q, intr_q, step_q, flags_q, cfg_q;
    logic [TC_W-1:0]   tc_q;

    scf_cmd_screen u_screen (.mode_ini(mode_ini), .group(wr_data[6:4]), .legal(legal));

    scf_seq_ctrl #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(wr_en && addr == A_CMD), .cfg_wr(wr_en && addr == A_CFG),
        .intr_rd(rd_en && addr == A_INTR), .wdata(wr_data), .legal(legal),
        .target_present(target_present), .dev_req(dev_req), .dev_phase(dev_phase),
        .cmd_q(cmd_q), .stat_q(stat_q), .intr_q(intr_q), .step_q(step_q),
        .flags_q(flags_q), .cfg_q(cfg_q), .mode_ini(mode_ini), .irq(irq));

    scf_tc_unit #(.DATA_W(DATA_W), .TC_W(TC_W)) u_tc (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && addr == A_TCL), .wr_hi(wr_en && addr == A_TCH),
        .wdata(wr_data), .burst_go(burst_go), .room(dma_room),
        .tc_q(tc_q), .mem_req(mem_req), .mem_len(mem_len));

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_CMD:   rd_data = cmd_q;
            A_STAT:  rd_data = stat_q;
            A_INTR:  rd_data = intr_q;
            A_STEP:  rd_data = step_q;
            A_FLAGS: rd_data = flags_q;
            A_CFG:   rd_data = cfg_q;
            A_TCL:   rd_data = tc_q[DATA_W-1:0];
            default: rd_data = tc_q[TC_W-1:DATA_W];
        endcase
    end
endmodule

// File: tb/scsi_cmd_front_tb_top.sv
module scsi_cmd_front_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, target_present = 0, dev_req = 0, burst_go = 0;
    logic [2:0] addr = 0, dev_phase = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic [15:0] dma_room = 0, mem_len;
    logic mem_req, mode_ini, irq;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scsi_cmd_front dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .target_present(target_present), .dev_req(dev_req),
        .dev_phase(dev_phase), .burst_go(burst_go), .dma_room(dma_room), .mem_req(mem_req),
        .mem_len(mem_len), .mode_ini(mode_ini), .irq(irq));

    function automatic bit exp_legal(input bit ini, input logic [7:0] b);
        logic [2:0] g = b[6:4];
        return (g == 3'd0) || (ini ? g == 3'd1 : g == 3'd4);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a; #0.5; d = rd_data;
    endtask

    task automatic rd_intr(output logic [7:0] d);
        @(negedge clk); addr = 3'd2; rd_en = 1; #0.5; d = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic dev(input logic [2:0] ph);
        @(negedge clk); dev_req = 1; dev_phase = ph;
        @(negedge clk); dev_req = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int dummy;
        dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v);
            chk("R1 reg", v, (a == 5) ? 7 : 0);
        end
        chk("R1 mode", mode_ini, 0);
        chk("R1 irq", irq, 0);

        // R2 R3 R4 random screening in both modes
        for (int m = 0; m < 2; m++) begin
            if (m == 1) begin
                target_present = 1;
                wr(3'd0, 8'h41);
                chk("R5 mode", mode_ini, 1);
                chk("R5 irq", irq, 0);
                dev(3'd6);
                peek(3'd2, v); chk("R6 intr", v, 8'h18);
                peek(3'd3, v); chk("R6 step", v, 4);
                peek(3'd4, v); chk("R12 flags", v, 6);
                chk("R6 irq", irq, 1);
                rd_intr(v); chk("R10 read", v, 8'h18);
                chk("R10 irq", irq, 0);
                peek(3'd2, v); chk("R10 cleared", v, 0);
            end
            for (int i = 0; i < 40; i++) begin
                logic [7:0] b, st0;
                bit lg;
                b = {1'($urandom), 3'($urandom), 4'(3 + $urandom % 13)};
                lg = exp_legal(bit'(m), b);
                rd_intr(v);
                peek(3'd3, st0);
                wr(3'd0, b);
                peek(3'd1, v); chk(lg ? "R2 legal status" : "R4 illegal status", v[7], !lg);
                chk(lg ? "R3 legal irq" : "R4 illegal irq", irq, !lg);
                peek(3'd0, v); chk("R4 cmd latch", v, b);
                peek(3'd3, v); chk("R4 step kept", v, st0);
                peek(3'd2, v); chk("R4 intr kept", v, 0);
                chk("R3 mode kept", mode_ini, m);
            end
        end
        rd_intr(v);

        // R8 transfer with target
        wr(3'd0, 8'h90);
        chk("R8 wait irq", irq, 0);
        dev(3'd1);
        peek(3'd0, v); chk("R8 cmd cleared", v, 0);
        peek(3'd2, v); chk("R8 intr", v, 8'h10);
        chk("R8 irq", irq, 1);
        rd_intr(v);

        // R9 message accepted
        wr(3'd0, 8'h12);
        chk("R9 mode", mode_ini, 0);
        peek(3'd2, v); chk("R9 intr", v, 8'h20);
        peek(3'd3, v); chk("R9 step", v, 0);
        peek(3'd4, v); chk("R9 flags", v, 0);
        chk("R9 irq", irq, 1);
        rd_intr(v);

        // R6 select with attention (DMA bit set)
        wr(3'd0, 8'hC2);
        chk("R5 mode atn", mode_ini, 1);
        dev(3'd3);
        peek(3'd2, v); chk("R6 atn intr", v, 8'h10);
        peek(3'd3, v); chk("R6 atn step", v, 1);
        peek(3'd4, v); chk("R12 flags atn", v, 3);
        rd_intr(v);

        // R7 transfer without target, with a stale illegal flag
        wr(3'd0, 8'h41);
        peek(3'd1, v); chk("R4 status set", v, 8'h80);
        target_present = 0;
        wr(3'd0, 8'h10);
        chk("R7 mode", mode_ini, 0);
        peek(3'd1, v); chk("R7 status", v, 0);
        peek(3'd2, v); chk("R7 intr", v, 8'h20);
        peek(3'd3, v); chk("R7 step", v, 0);
        chk("R7 irq", irq, 1);
        rd_intr(v);
        wr(3'd0, 8'h41);
        chk("R7 sel mode", mode_ini, 0);
        peek(3'd2, v); chk("R7 sel intr", v, 8'h20);
        rd_intr(v);

        // R11 bursts
        for (int i = 0; i < 40; i++) begin
            logic [15:0] tc, rm, ln, t2;
            tc = (i % 5 == 0) ? 16'd0 : 16'($urandom);
            rm = (i % 7 == 1) ? 16'd0 : ((i % 3 == 0) ? tc : 16'($urandom));
            ln = (tc < rm) ? tc : rm;
            wr(3'd6, tc[7:0]);
            wr(3'd7, tc[15:8]);
            @(negedge clk); burst_go = 1; dma_room = rm;
            @(negedge clk); burst_go = 0;
            chk("R11 mem_req", mem_req, ln != 0);
            if (ln != 0) chk("R11 mem_len", mem_len, ln);
            peek(3'd6, v); t2[7:0] = v;
            peek(3'd7, v); t2[15:8] = v;
            chk("R11 counter", t2, tc - ln);
            @(negedge clk);
            chk("R11 pulse one cycle", mem_req, 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule